// File: doc/BRIEF.md
# SPI Memory Command Front-End

This block is the slave side of a small serial memory. It watches chip select, serial clock, data in and an active-low hold line. It decodes an 8-bit opcode and, for array commands, a two-byte address. It returns array data or the status byte on the serial output. Array writes and status writes are forwarded to downstream logic as one-cycle strobes. A register-file model of the 4096 x 8 array sits inside the block, so read-back works without any outside logic.

All serial inputs are sampled on a fast system clock, and both serial clock edges are detected from that sampling. Input bits are taken on a rising serial clock edge. Output bits change on a falling edge. Both idle polarities are handled: clock low at select (mode 0) and clock high at select (mode 3). Because the output cannot float inside the core, it is presented as a data bit plus an output-enable. A low enable stands for high impedance.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset, and whenever `cs_n` is high, `miso_oe` is 0 and no write strobe is issued.
- R2: Commands are decoded the same way whether the serial clock idles low (mode 0) or high (mode 3) when `cs_n` falls. Only rising edges sample `mosi`, and a leading falling edge is ignored.
- R3: Opcode 03h reads the array. It takes a high and a low address byte, and only the low 12 bits of the address are used. The first data bit appears on the falling edge after the 24th rising edge. Bytes go out MSB first, and the address advances by one for each byte.
- R4: A read that passes address 0FFFh continues at 0000h.
- R5: Opcode 05h returns the status byte `{sr_upper_i[5:0], wen, busy_i}`, bit 7 first. Output starts on the falling edge after the 8th rising edge and repeats for as long as the clock runs.
- R6: Opcode 05h is served while `busy_i` is 1.
- R7: Opcode 06h sets `wen` and opcode 04h clears it. A rising `cs_n` after at least one accepted write byte clears `wen`. A partial byte leaves `wen` unchanged.
- R8: Opcode 02h with `wen` set stores each complete data byte at the current address. It then advances only the low 5 address bits, wrapping within the 32-byte page. Each stored byte raises `wcmd_valid` for one cycle with `wcmd_status`=0 and the address and data of that byte. With `wen` clear, or for a partial byte, nothing is stored or strobed.
- R9: Opcode 01h with `wen` set forwards its first data byte as a strobe with `wcmd_status`=1 and `wcmd_addr`=0.
- R10: `hold_n` falling while `cs_n` is low and the serial clock is low enters hold. In hold, `miso_oe` is 0 and clock edges are ignored. `hold_n` rising leaves hold, and the transfer resumes where it stopped.
- R11: A rising `cs_n` ends any command and clears the bit and byte counters, including during hold. After an unknown opcode, `miso_oe` stays 0 until `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low hold |
| busy_i | input | 1 | Downstream write in progress; status bit 0 |
| sr_upper_i | input | 6 | Status bits 7 to 2 from downstream |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso`; 0 means high impedance |
| wcmd_valid | output | 1 | One-cycle strobe for an accepted write byte |
| wcmd_status | output | 1 | 1 for a status write, 0 for an array write |
| wcmd_addr | output | 12 | Array address of the strobed byte |
| wcmd_data | output | 8 | Strobed data byte |

## Verification
The assertions assume that the serial pins change synchronously to `clk` and that each serial clock phase lasts several system clocks. They also assume that `hold_n` only moves while the serial clock is low, and that `cs_n` stays high through reset. The bench drives every pin on the falling system clock edge with four-cycle serial clock phases. It toggles hold only with the serial clock low, and it switches between both idle polarities from one transaction to the next, so it stays within those assumptions.

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend #(
  parameter int AW = 12,
  parameter int PAGE_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          mosi,
  input  logic          hold_n,
  input  logic          busy_i,
  input  logic [5:0]    sr_upper_i,
  output logic          miso,
  output logic          miso_oe,
  output logic          wcmd_valid,
  output logic          wcmd_status,
  output logic [AW-1:0] wcmd_addr,
  output logic [7:0]    wcmd_data
);
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_RDSR = 8'h05,
                         OP_WRSR = 8'h01, OP_READ = 8'h03, OP_WRITE = 8'h02;

  logic [7:0]    mem [DEPTH];
  logic          sck_q, hold_q, cs_q, held, wen, wrote, driving;
  logic [2:0]    bitcnt, obit;
  logic [1:0]    bytecnt;
  logic [6:0]    sin;
  logic [7:0]    opcode, tx;
  logic [AW-1:0] addr;

  wire       active  = !cs_n && !held;
  wire       rise    = active && sck && !sck_q;
  wire       fall    = active && !sck && sck_q;
  wire [7:0] rx_byte = {sin, mosi};
  wire       byte_done = rise && (bitcnt == 3'd7);
  wire [7:0] status  = {sr_upper_i, wen, busy_i};
  wire       rd_go   = (opcode == OP_READ && bytecnt == 2'd3) ||
                       (opcode == OP_RDSR && bytecnt != 2'd0);
  wire [7:0] src     = (opcode == OP_READ) ? mem[addr] : status;
  wire       mem_we  = byte_done && bytecnt == 2'd3 && opcode == OP_WRITE && wen;

  assign miso_oe = driving && !held && !cs_n;

  always_ff @(posedge clk)
    if (mem_we) mem[addr] <= rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0; hold_q <= 1'b1; cs_q <= 1'b1; held <= 1'b0;
      wen <= 1'b0; wrote <= 1'b0; driving <= 1'b0;
      bitcnt <= '0; obit <= '0; bytecnt <= '0; sin <= '0;
      opcode <= '0; tx <= '0; addr <= '0; miso <= 1'b0;
      wcmd_valid <= 1'b0; wcmd_status <= 1'b0; wcmd_addr <= '0; wcmd_data <= '0;
    end else begin
      sck_q <= sck; hold_q <= hold_n; cs_q <= cs_n;
      wcmd_valid <= 1'b0;
      if (cs_n) begin
        bitcnt <= '0; bytecnt <= '0; obit <= '0; opcode <= '0;
        held <= 1'b0; driving <= 1'b0;
        if (!cs_q && wrote) wen <= 1'b0;
        wrote <= 1'b0;
      end else begin
        if (held) begin
          if (hold_n && !hold_q) held <= 1'b0;
        end else if (hold_q && !hold_n && !sck) begin
          held <= 1'b1;
        end
        if (rise) begin
          bitcnt <= bitcnt + 3'd1;
          sin <= rx_byte[6:0];
          if (byte_done) begin
            if (bytecnt != 2'd3) bytecnt <= bytecnt + 2'd1;
            case (bytecnt)
              2'd0: begin
                opcode <= rx_byte;
                if (rx_byte == OP_WREN) wen <= 1'b1;
                if (rx_byte == OP_WRDI) wen <= 1'b0;
              end
              2'd1: begin
                addr[AW-1:8] <= rx_byte[AW-9:0];
                if (opcode == OP_WRSR && wen) begin
                  wcmd_valid <= 1'b1; wcmd_status <= 1'b1;
                  wcmd_addr <= '0; wcmd_data <= rx_byte; wrote <= 1'b1;
                end
              end
              2'd2: addr[7:0] <= rx_byte;
              default: if (mem_we) begin
                wcmd_valid <= 1'b1; wcmd_status <= 1'b0;
                wcmd_addr <= addr; wcmd_data <= rx_byte; wrote <= 1'b1;
                addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
              end
            endcase
          end
        end
        if (fall && rd_go) begin
          driving <= 1'b1;
          obit <= obit + 3'd1;
          if (obit == 3'd0) begin
            tx <= src;
            miso <= src[7];
            if (opcode == OP_READ) addr <= addr + 1'b1;
          end else begin
            miso <= tx[3'd7 - obit];
          end
        end
      end
    end
  end

  AST_STROBE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    wcmd_valid |-> wen); // R8
  AST_WEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && wrote) |=> !wen); // R7
  AST_CS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bitcnt == 3'd0 && bytecnt == 2'd0 && !held)); // R11
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> ($stable(bitcnt) && $stable(obit))); // R10
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (opcode == OP_READ || opcode == OP_RDSR)); // R11
endmodule

// File: tb/spi_mem_frontend_tb.sv
module spi_mem_frontend_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, busy_i = 1'b1;
  logic [5:0] sr_upper_i = 6'b101101;
  logic miso, miso_oe, wcmd_valid, wcmd_status;
  logic [11:0] wcmd_addr;
  logic [7:0] wcmd_data;

  int checks = 0, errors = 0;
  int exp_mem [4096];
  bit exp_wen = 1'b0;
  bit mode3 = 1'b0;
  logic [20:0] sq [$];

  always #2 clk = ~clk;

  spi_mem_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .hold_n(hold_n),
    .busy_i(busy_i), .sr_upper_i(sr_upper_i), .miso(miso), .miso_oe(miso_oe),
    .wcmd_valid(wcmd_valid), .wcmd_status(wcmd_status), .wcmd_addr(wcmd_addr),
    .wcmd_data(wcmd_data));

  always @(negedge clk) if (wcmd_valid) sq.push_back({wcmd_status, wcmd_addr, wcmd_data});

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cs_begin();
    sck <= mode3; mosi <= 1'b0;
    repeat (2) @(negedge clk);
    cs_n <= 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_end();
    if (!mode3) begin sck <= 1'b0; repeat (4) @(negedge clk); end
    cs_n <= 1'b1;
    repeat (4) @(negedge clk);
    check(miso_oe == 1'b0, "R1 oe low after deselect", miso_oe, 0);
  endtask

  task automatic xbit(input logic b, output logic r, output logic o);
    sck <= 1'b0; mosi <= b;
    repeat (4) @(negedge clk);
    r = miso; o = miso_oe;
    sck <= 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r, output bit any_oe, output bit all_oe);
    logic rb, ob;
    any_oe = 1'b0; all_oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      xbit(b[i], rb, ob);
      r[i] = rb;
      any_oe |= ob; all_oe &= ob;
    end
  endtask

  task automatic do_rdsr(input int n, input string req);
    logic [7:0] r, e;
    bit a, l;
    cs_begin();
    xbyte(8'h05, r, a, l);
    check(!a, {req, " oe during opcode"}, a, 0);
    e = {sr_upper_i, exp_wen, busy_i};
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, r, a, l);
      check(r == e && l, req, {l, r}, {1'b1, e});
    end
    cs_end();
  endtask

  task automatic simple(input logic [7:0] op);
    logic [7:0] r;
    bit a, l;
    cs_begin(); xbyte(op, r, a, l); cs_end();
    if (op == 8'h06) exp_wen = 1'b1;
    if (op == 8'h04) exp_wen = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input int seed, input string req);
    logic [7:0] r, d;
    logic [11:0] wa;
    logic [20:0] ent;
    bit x, y;
    sq.delete();
    wa = a[11:0];
    cs_begin();
    xbyte(8'h02, r, x, y); xbyte(a[15:8], r, x, y); xbyte(a[7:0], r, x, y);
    for (int k = 0; k < n; k++) begin
      d = 8'((seed + k * 13) & 255);
      xbyte(d, r, x, y);
      if (exp_wen) begin
        exp_mem[wa] = d;
        check(sq.size() > 0, {req, " strobe present"}, sq.size(), 1);
        if (sq.size() > 0) begin
          ent = sq.pop_front();
          check(ent == {1'b0, wa, d}, {req, " strobe content"}, ent, {1'b0, wa, d});
        end
      end
      wa = {wa[11:5], wa[4:0] + 5'd1};
    end
    cs_end();
    if (!exp_wen) check(sq.size() == 0, {req, " no strobe without wen"}, sq.size(), 0);
    if (n > 0) exp_wen = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input string req);
    logic [7:0] r;
    logic [11:0] ra;
    bit x, l;
    ra = a[11:0];
    cs_begin();
    xbyte(8'h03, r, x, l); xbyte(a[15:8], r, x, l); xbyte(a[7:0], r, x, l);
    check(!x, {req, " oe before data"}, x, 0);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, r, x, l);
      check(r == 8'(exp_mem[ra]) && l, req, {l, r}, {1'b1, 8'(exp_mem[ra])});
      ra = ra + 12'd1;
    end
    cs_end();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    logic [7:0] r, e;
    logic rb, ob;
    bit a, l;
    repeat (5) @(negedge clk);
    rst_n <= 1'b1;
    repeat (3) @(negedge clk);
    check(miso_oe == 0 && wcmd_valid == 0, "R1 reset state", {miso_oe, wcmd_valid}, 0);

    mode3 = 1'b0; do_rdsr(3, "R5 R6 R2 status repeat mode0");
    mode3 = 1'b1; simple(8'h06);
    do_rdsr(2, "R7 R2 wen set mode3");
    do_write(16'hAFE0, 32, 7, "R8 R3 page at 0FE0");
    do_rdsr(1, "R7 wen cleared after write");
    mode3 = 1'b0; simple(8'h06);
    do_write(16'h0000, 32, 91, "R8 page at 0000");
    mode3 = 1'b1; do_read(16'h5FF0, 40, "R3 R4 read across wrap");

    mode3 = 1'b0; simple(8'h06);
    do_write(16'h0FFE, 4, 160, "R8 page wrap write");
    do_read(16'h0FFE, 2, "R8 page wrap top");
    do_read(16'h0FE0, 3, "R8 page wrap bottom");

    do_write(16'h0005, 1, 153, "R8 write without wen");
    do_read(16'h0004, 3, "R8 memory unchanged without wen");

    simple(8'h06);
    sq.delete();
    cs_begin();
    xbyte(8'h02, r, a, l); xbyte(8'h00, r, a, l); xbyte(8'h06, r, a, l);
    for (int i = 0; i < 5; i++) xbit(1'b1, rb, ob);
    cs_end();
    check(sq.size() == 0, "R8 partial byte no strobe", sq.size(), 0);
    do_rdsr(1, "R7 wen kept after partial byte");
    do_read(16'h0006, 1, "R8 partial byte not stored");
    simple(8'h04);
    do_rdsr(1, "R7 wen cleared by 04h");

    simple(8'h06);
    sq.delete();
    cs_begin(); xbyte(8'h01, r, a, l); xbyte(8'h8C, r, a, l); cs_end();
    check(sq.size() == 1, "R9 one status strobe", sq.size(), 1);
    if (sq.size() > 0) check(sq[0] == {1'b1, 12'h000, 8'h8C}, "R9 status strobe content", sq[0], {1'b1, 12'h000, 8'h8C});
    exp_wen = 1'b0;
    do_rdsr(1, "R7 wen cleared after status write");

    mode3 = 1'b1;
    cs_begin();
    xbyte(8'hAB, r, a, l);
    for (int k = 0; k < 3; k++) begin
      xbyte(8'h00, r, a, l);
      check(!a, "R11 unknown opcode keeps oe low", a, 0);
    end
    cs_end();

    mode3 = 1'b0;
    cs_begin();
    xbyte(8'h03, r, a, l); xbyte(8'h00, r, a, l); xbyte(8'h10, r, a, l);
    xbyte(8'h00, r, a, l);
    check(r == 8'(exp_mem[16]), "R10 byte before hold", r, exp_mem[16]);
    e = 8'(exp_mem[17]);
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) begin
        sck <= 1'b0; repeat (4) @(negedge clk);
        hold_n <= 1'b0; repeat (4) @(negedge clk);
        check(miso_oe == 0, "R10 oe off in hold", miso_oe, 0);
        for (int t = 0; t < 3; t++) begin
          sck <= 1'b1; repeat (4) @(negedge clk);
          sck <= 1'b0; repeat (4) @(negedge clk);
        end
        hold_n <= 1'b1; repeat (4) @(negedge clk);
      end
      xbit(1'b0, rb, ob);
      r[i] = rb;
    end
    check(r == e && ob, "R10 transfer resumes after hold", {ob, r}, {1'b1, e});
    xbyte(8'h00, r, a, l);
    check(r == 8'(exp_mem[18]) && l, "R10 next byte after hold", r, exp_mem[18]);
    sck <= 1'b0; repeat (4) @(negedge clk);
    hold_n <= 1'b0; repeat (4) @(negedge clk);
    cs_n <= 1'b1; repeat (4) @(negedge clk);
    hold_n <= 1'b1; repeat (4) @(negedge clk);
    check(miso_oe == 0, "R11 oe off after deselect in hold", miso_oe, 0);
    do_rdsr(2, "R11 clean command after deselect in hold");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule